// File: doc/BRIEF.md
# General-Purpose I/O Port with Pad Readback

This block controls a parameterized bank of general-purpose pins (32 by default) from a small memory-mapped register bus. Software selects the direction of each pin through a direction register. It places output values in a data register, which the block drives toward the pads together with a per-pin output-enable vector. The block samples the pad input vector through a two-flop synchronizer. It returns the synchronized values through the data register for pins set as inputs, and through a read-only pad status register.

A per-pin loopback input stands in for the pad's input-path enable. When loopback is set on an output pin, the status register shows the value being driven on that pin. Without loopback, the status register reports 0 for that output pin. Writes finish one cycle after they are accepted. Reads insert two wait states so that the returned data reflects the synchronized pad state.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, `pad_oe` and `pad_out` are all zero, every pin is an input, and `ready` and `rdata` are zero.
- R2: `pad_oe[i]` equals the stored direction bit i, where 1 means output. `pad_out[i]` equals the stored data bit i.
- R3: A write (`req`=1, `we`=1) seen on a rising edge while `ready` is low is accepted on that edge. The addressed register takes the new value on that same edge, and `ready` is high for exactly the one following cycle.
- R4: A read (`req`=1, `we`=0) accepted on a rising edge raises `ready` only after the third rising edge, which gives two wait states. `ready` stays high for one cycle. `rdata` changes only when `ready` rises and then holds its value.
- R5: A read of offset 0x0 returns, for each bit, the stored data bit where the direction bit is 1 and the synchronized pad input where it is 0.
- R6: `pad_in` passes through two flops before it reaches either read path. The value seen on the read paths after an edge equals `pad_in` as sampled two edges earlier.
- R7: A read of offset 0x8 returns, per bit: the synchronized pad input when direction is 0; the stored data bit when direction is 1 and `loop_en` is 1; and 0 when direction is 1 and `loop_en` is 0.
- R8: The word offsets are 0x0 for data, 0x4 for direction, 0x8 for status and 0xC reserved, decoded from `addr[3:2]`. Writes to 0x8 or 0xC change no register but still complete. Reads of 0xC return 0.
- R9: Writing the data register while a pin is an input stores the bit. That bit appears on `pad_out` and is enabled as soon as the pin's direction bit is set.
- R10: With the low four direction bits set, data 0x5 written and loopback on those pins, a read of the status register returns 0x5 in its low nibble.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus request, held until `ready` is seen |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | WIDTH | Write data |
| rdata | output | WIDTH | Read data, valid while `ready` is high |
| ready | output | 1 | One-cycle completion pulse |
| loop_en | input | WIDTH | Per-pin loopback (input path) enable |
| pad_in | input | WIDTH | Asynchronous pad input values |
| pad_out | output | WIDTH | Values driven toward the pads |
| pad_oe | output | WIDTH | Per-pin output enable |

## Verification
On every cycle, the assertions check the handshake timing: the single-cycle write completion, the two-wait-state read completion, the one-cycle `ready` pulse and that `rdata` holds between reads. They also check the two-flop input latency, the reset values and that status or reserved writes leave the pads alone. The read-value selection is checked by the bench, which compares every read with a model built from the stored registers, the loopback vector and the pad inputs. That covers the per-bit mix of data and pad values, the three status cases, reserved reads and the store-while-input behaviour.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  typedef enum logic [1:0] {
    SEL_DATA = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_STAT = 2'd2,
    SEL_RSVD = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_WAIT = 2'd1
  } bus_state_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage_q[g] <= '0;
          else     stage_q[g] <= stage_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_stb,
  input  reg_sel_e         wr_sel,
  input  logic [WIDTH-1:0] wr_val,
  output logic [WIDTH-1:0] data_q,
  output logic [WIDTH-1:0] dir_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      dir_q  <= '0;
    end else if (wr_stb) begin
      case (wr_sel)
        SEL_DATA: data_q <= wr_val;
        SEL_DIR:  dir_q  <= wr_val;
        default:  ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_readmux.sv
module gpio_readmux
  import gpio_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  reg_sel_e         sel,
  input  logic [WIDTH-1:0] data_q,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] pad_sync,
  input  logic [WIDTH-1:0] loop_en,
  output logic [WIDTH-1:0] rd_val
);

  logic [WIDTH-1:0] data_view;
  logic [WIDTH-1:0] stat_view;

  genvar b;
  generate
    for (b = 0; b < WIDTH; b++) begin : g_bit
      always_comb begin
        if (dir_q[b]) begin
          data_view[b] = data_q[b];
          stat_view[b] = loop_en[b] & data_q[b];
        end else begin
          data_view[b] = pad_sync[b];
          stat_view[b] = pad_sync[b];
        end
      end
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_DATA: rd_val = data_view;
      SEL_DIR:  rd_val = dir_q;
      SEL_STAT: rd_val = stat_view;
      default:  rd_val = '0;
    endcase
  end

endmodule

// File: rtl/gpio_bus.sv
module gpio_bus
  import gpio_pkg::*;
#(
  parameter int WIDTH      = 32,
  parameter int READ_WAITS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             we,
  input  reg_sel_e         sel_in,
  input  logic [WIDTH-1:0] rd_val,
  output logic             wr_stb,
  output reg_sel_e         rd_sel,
  output logic             idle,
  output logic             ready,
  output logic [WIDTH-1:0] rdata
);

  localparam int CNT_W = $clog2(READ_WAITS + 1);

  bus_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign idle   = (state_q == BUS_IDLE);
  assign accept = idle && req && !ready;
  assign wr_stb = accept && we;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      cnt_q   <= '0;
      rd_sel  <= SEL_RSVD;
      ready   <= 1'b0;
      rdata   <= '0;
    end else begin
      ready <= 1'b0;
      case (state_q)
        BUS_IDLE: begin
          if (accept) begin
            if (we) begin
              ready <= 1'b1;
            end else begin
              rd_sel  <= sel_in;
              cnt_q   <= '0;
              state_q <= BUS_WAIT;
            end
          end
        end
        default: begin
          if (cnt_q == CNT_W'(READ_WAITS - 1)) begin
            rdata   <= rd_val;
            ready   <= 1'b1;
            state_q <= BUS_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2,
  parameter int READ_WAITS  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIDTH-1:0]  wdata,
  output logic [WIDTH-1:0]  rdata,
  output logic              ready,
  input  logic [WIDTH-1:0]  loop_en,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe
);

  reg_sel_e         addr_sel;
  reg_sel_e         rd_sel;
  logic             wr_stb;
  logic             fsm_idle;
  logic [WIDTH-1:0] data_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] pad_sync;
  logic [WIDTH-1:0] rd_val;

  generate
    if (ADDR_W > 4) begin : g_wide_addr
      assign addr_sel = (addr[ADDR_W-1:4] == '0) ? reg_sel_e'(addr[3:2]) : SEL_RSVD;
    end else begin : g_narrow_addr
      assign addr_sel = reg_sel_e'(addr[3:2]);
    end
  endgenerate

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (pad_in),
    .dout(pad_sync)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .wr_stb(wr_stb),
    .wr_sel(addr_sel),
    .wr_val(wdata),
    .data_q(data_q),
    .dir_q (dir_q)
  );

  gpio_readmux #(.WIDTH(WIDTH)) u_rmux (
    .sel     (rd_sel),
    .data_q  (data_q),
    .dir_q   (dir_q),
    .pad_sync(pad_sync),
    .loop_en (loop_en),
    .rd_val  (rd_val)
  );

  gpio_bus #(.WIDTH(WIDTH), .READ_WAITS(READ_WAITS)) u_bus (
    .clk   (clk),
    .rst   (rst),
    .req   (req),
    .we    (we),
    .sel_in(addr_sel),
    .rd_val(rd_val),
    .wr_stb(wr_stb),
    .rd_sel(rd_sel),
    .idle  (fsm_idle),
    .ready (ready),
    .rdata (rdata)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic [WIDTH-1:0]  rdata,
  input logic [WIDTH-1:0]  pad_in,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic              idle,
  input logic [WIDTH-1:0]  sync_q
);

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (pad_oe == '0 && pad_out == '0 && !ready && rdata == '0));

  a_r3_write_ack: assert property (@(posedge clk) disable iff (rst)
    (idle && req && we && !ready) |=> ready);

  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  a_r4_read_waits: assert property (@(posedge clk) disable iff (rst)
    (idle && req && !we && !ready) |=> !ready ##1 !ready ##1 ready);

  a_r4_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !$stable(rdata) |-> ready);

  a_r6_sync_delay: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(rst, 2)) |-> sync_q == $past(pad_in, 2));

  a_r8_stat_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (idle && req && we && !ready && addr[3]) |=> ($stable(pad_out) && $stable(pad_oe)));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .req    (req),
  .we     (we),
  .addr   (addr),
  .ready  (ready),
  .rdata  (rdata),
  .pad_in (pad_in),
  .pad_out(pad_out),
  .pad_oe (pad_oe),
  .idle   (fsm_idle),
  .sync_q (pad_sync)
);

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;

  localparam int W = 32;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [W-1:0]  rdata;
  logic          ready;
  logic [W-1:0]  loop_en = '0;
  logic [W-1:0]  pad_in = '0;
  logic [W-1:0]  pad_out;
  logic [W-1:0]  pad_oe;

  int checks = 0;
  int bad = 0;

  logic [W-1:0] m_data = '0;
  logic [W-1:0] m_dir = '0;

  always #2.5 clk = ~clk;

  gpio_port #(.WIDTH(W), .ADDR_W(AW)) i_gpio_port (
    .clk(clk), .rst(rst), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .loop_en(loop_en), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_data();
    return (m_dir & m_data) | (~m_dir & pad_in);
  endfunction

  function automatic logic [W-1:0] exp_stat();
    return (~m_dir & pad_in) | (m_dir & loop_en & m_data);
  endfunction

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_op(input logic is_wr, input logic [AW-1:0] a,
                        input logic [W-1:0] d, output logic [W-1:0] rd, output int lat);
    req = 1'b1; we = is_wr; addr = a; wdata = d;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready && lat < 20);
    rd = rdata;
    req = 1'b0; we = 1'b0;
    @(negedge clk);
    check("R4 ready single cycle", {31'd0, ready}, '0);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    logic [W-1:0] rd;
    int lat;
    bus_op(1'b1, a, d, rd, lat);
    check("R3 write latency", W'(lat), W'(1));
    if (a[3:2] == 2'd0) m_data = d;
    if (a[3:2] == 2'd1) m_dir = d;
    check("R2 pad_out", pad_out, m_data);
    check("R2 pad_oe", pad_oe, m_dir);
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string tag, input logic [W-1:0] exp);
    logic [W-1:0] rd;
    int lat;
    bus_op(1'b0, a, '0, rd, lat);
    check("R4 read latency", W'(lat), W'(3));
    check(tag, rd, exp);
    repeat (2) @(negedge clk);
    check("R4 rdata held", rdata, rd);
  endtask

  initial begin
    #(5.0 * 200000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pad_oe reset", pad_oe, '0);
    check("R1 pad_out reset", pad_out, '0);
    check("R1 rdata reset", rdata, '0);
    check("R1 ready reset", {31'd0, ready}, '0);

    // R10 directed loopback scenario
    loop_en = 32'h0000_000F;
    do_write(4'h4, 32'h0000_000F);
    do_write(4'h0, 32'h0000_0005);
    do_read(4'h8, "R10 status low nibble", exp_stat());
    check("R10 nibble value", exp_stat() & 32'hF, 32'h5);

    // R7 output pins without loopback read 0
    loop_en = '0;
    pad_in = 32'hFFFF_FFFF;
    settle();
    do_read(4'h8, "R7 status no loop", 32'hFFFF_FFF0);

    // R9 store while input, then drive
    do_write(4'h4, '0);
    do_write(4'h0, 32'hA5A5_0000);
    check("R9 oe still off", pad_oe, '0);
    do_read(4'h0, "R5 input bits read pads", pad_in);
    do_write(4'h4, 32'hFFFF_0000);
    check("R9 stored bits driven", pad_out & pad_oe, 32'hA5A5_0000);

    // R8 writes to status and reserved change nothing; reserved reads 0
    do_write(4'h8, 32'h1234_5678);
    do_write(4'hC, 32'h8765_4321);
    do_read(4'h0, "R8 data unchanged", exp_data());
    do_read(4'h4, "R8 dir unchanged", 32'hFFFF_0000);
    do_read(4'hC, "R8 reserved read", '0);

    // R6 pad change seen after synchronizer
    pad_in = 32'h0F0F_3C3C;
    settle();
    do_read(4'h0, "R6 R5 pad sync data", exp_data());

    for (int i = 0; i < 300; i++) begin
      int op;
      op = $urandom_range(0, 7);
      case (op)
        0: do_write(4'h0, $urandom());
        1: do_write(4'h4, $urandom());
        2: do_write({$urandom_range(2, 3), 2'b00}, $urandom());
        3: begin pad_in = $urandom(); settle(); end
        4: loop_en = $urandom();
        5: do_read(4'h0, "R5 random data read", exp_data());
        6: do_read(4'h8, "R7 random status read", exp_stat());
        default: do_read(4'h4, "R3 random dir read", m_dir);
      endcase
    end

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule